// File: doc/BRIEF.md
# Prescaled Timer and Event Counter

This block counts periods of either an internal slow time base or rising edges on an external event pin. A 5-bit prescaler divides the selected tick stream, and each prescaler underflow steps an 8-bit down-counter. Together the two stages span 13 bits. When the down-counter is at zero and receives a step, it reloads a host-programmed value and raises a single-cycle interrupt request. The time base is a free-running enable that fires once every sixteen clocks.

A host configures the block through a small write port. The port selects one of three registers: the counter reload value, the prescale value and a control byte. The control byte holds a run bit and a source-select bit. When the run bit goes from 0 to 1, both stages load from their reload registers. Clearing the run bit freezes both stages. The current count can be read on a dedicated output at all times.

Top module: `tmr_evt_counter`

## Requirements
- R1: After reset the count output is 0 and the interrupt output is low.
- R2: With source-select 0 (control bit 1 = 0), a count tick occurs once every 16 clocks from a free-running divider that starts at reset, and it advances the prescaler.
- R3: The prescaler counts ticks down from the programmed value P (write select 1, data bits 4:0). When it is at 0 and a tick arrives, it reloads P and issues one step to the counter. Steps therefore occur every P+1 ticks.
- R4: On a step, the counter decrements. If a step arrives while the counter is at 0, it reloads N (write select 0) and drives the interrupt high for exactly one clock. The interrupt rises in the cycle after the reloading edge.
- R5: With source-select 1, the event input passes through two synchronizing flops. Only a rising edge produces a tick, two edges after the pin rises. A held level or a falling edge produces none.
- R6: A control write (select 2) with the run bit (bit 0) set while the block is stopped loads the prescaler with P and the counter with N, using the register values held before that edge. Counting starts on the next cycle.
- R7: While the run bit is clear, the count output and the prescaler hold their values, and the interrupt stays low.
- R8: A control write with the run bit set while the block is already running reloads neither stage.
- R9: A write with select code 3 changes no state.
- R10: A reload-value write in the same cycle as a terminal-count reload has no effect on that reload, which uses the previous N. The new N applies from the next reload.
- R11: Ticks from the source that is not selected have no effect on the count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Host write strobe |
| wr_sel | input | 2 | Write target: 0 reload N, 1 prescale P, 2 control, 3 none |
| wr_data | input | 8 | Write data |
| evt_in | input | 1 | External event pin (asynchronous) |
| cnt_q | output | 8 | Current counter value |
| irq | output | 1 | One-cycle timer interrupt request |

## Verification
Two events can fall on the same clock edge: a host write of the reload value, and a terminal-count reload of the counter. The bench provokes this with the smallest settings (N of 1 or 2, P of 0) and an event pin that toggles fast. It writes an alternating N on every cycle, so every terminal reload coincides with a write. A behavioural model updates its registers only after it evaluates the count step. The model is compared with the count and interrupt outputs on every clock, so a design that reloads with the freshly written value diverges at once.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [1:0] {
    SEL_RELOAD   = 2'd0,
    SEL_PRESCALE = 2'd1,
    SEL_CTRL     = 2'd2,
    SEL_NONE     = 2'd3
  } wsel_e;

  localparam int CTRL_RUN_BIT = 0;
  localparam int CTRL_SRC_BIT = 1;
endpackage

// File: rtl/tmr_base_div.sv
module tmr_base_div #(
  parameter int DIV_W = 4
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick_o
);
  logic [DIV_W-1:0] div_q, div_d;

  always_comb begin
    div_d = div_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_d;
  end

  assign tick_o = &div_q;

  // R2: base ticks are isolated single-cycle enables
  p_tick_spacing_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |=> !tick_o);
endmodule

// File: rtl/tmr_evt_sync.sv
module tmr_evt_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic evt_i,
  output logic rise_o
);
  logic [STAGES-1:0] sync_q, sync_d;
  logic              last_q;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], evt_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      last_q <= sync_q[STAGES-1];
    end
  end

  assign rise_o = sync_q[STAGES-1] & ~last_q;

  // R5: an edge yields exactly one tick
  p_rise_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |=> !rise_o);
endmodule

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
  parameter int PRE_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic             run_i,
  input  logic             tick_i,
  input  logic [PRE_W-1:0] reload_i,
  output logic             cen_o
);
  logic [PRE_W-1:0] pre_q, pre_d;
  logic             pre_en;
  logic             at_zero;

  assign at_zero = (pre_q == '0);
  assign cen_o   = run_i & tick_i & at_zero;

  always_comb begin
    pre_en = load_i | (run_i & tick_i);
    if (load_i)       pre_d = reload_i;
    else if (at_zero) pre_d = reload_i;
    else              pre_d = pre_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pre_q <= '0;
    else if (pre_en) pre_q <= pre_d;
  end

  // R3: a step leaves the prescaler holding the programmed value
  p_pre_reload_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cen_o |=> (pre_q == $past(reload_i)));
  // R7: stopped prescaler is frozen unless loaded
  p_pre_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_i && !load_i) |=> $stable(pre_q));
endmodule

// File: rtl/tmr_modn.sv
module tmr_modn #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic             cen_i,
  input  logic [CNT_W-1:0] reload_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             irq_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;
  logic             term;
  logic             irq_q, irq_d;

  assign term = cen_i & (cnt_q == '0);

  always_comb begin
    cnt_en = load_i | cen_i;
    if (load_i || term) cnt_d = reload_i;
    else                cnt_d = cnt_q - 1'b1;
    irq_d = term;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      irq_q <= 1'b0;
    end else begin
      irq_q <= irq_d;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end

  assign cnt_o = cnt_q;
  assign irq_o = irq_q;

  // R4: interrupt coincides with the counter holding the reload value
  p_irq_reload_r4: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> (cnt_q == $past(reload_i)));
  // R4: interrupt is a single-cycle pulse
  p_irq_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |=> !irq_q);
endmodule

// File: rtl/tmr_evt_counter.sv
module tmr_evt_counter
  import tmr_pkg::*;
#(
  parameter int PRE_W       = 5,
  parameter int CNT_W       = 8,
  parameter int DIV_W       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             evt_in,
  output logic [CNT_W-1:0] cnt_q,
  output logic             irq
);
  localparam int TOTAL_W = PRE_W + CNT_W;

  logic [CNT_W-1:0] n_q, n_d;
  logic [PRE_W-1:0] p_q, p_d;
  logic             run_q, run_d;
  logic             src_q, src_d;
  logic             wr_n, wr_p, wr_c;
  logic             start;
  logic             tick_int, tick_ext, tick;
  logic             cen;

  assign wr_n = wr_en & (wsel_e'(wr_sel) == SEL_RELOAD);
  assign wr_p = wr_en & (wsel_e'(wr_sel) == SEL_PRESCALE);
  assign wr_c = wr_en & (wsel_e'(wr_sel) == SEL_CTRL);

  assign start = wr_c & wr_data[CTRL_RUN_BIT] & ~run_q;

  always_comb begin
    n_d   = wr_n ? wr_data : n_q;
    p_d   = wr_p ? wr_data[PRE_W-1:0] : p_q;
    run_d = wr_c ? wr_data[CTRL_RUN_BIT] : run_q;
    src_d = wr_c ? wr_data[CTRL_SRC_BIT] : src_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      n_q   <= '0;
      p_q   <= '0;
      run_q <= 1'b0;
      src_q <= 1'b0;
    end else begin
      n_q   <= n_d;
      p_q   <= p_d;
      run_q <= run_d;
      src_q <= src_d;
    end
  end

  tmr_base_div #(.DIV_W(DIV_W)) i_div (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick_o (tick_int)
  );

  tmr_evt_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .evt_i  (evt_in),
    .rise_o (tick_ext)
  );

  assign tick = src_q ? tick_ext : tick_int;

  tmr_prescale #(.PRE_W(PRE_W)) i_pre (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_i   (start),
    .run_i    (run_q),
    .tick_i   (tick),
    .reload_i (p_q),
    .cen_o    (cen)
  );

  tmr_modn #(.CNT_W(CNT_W)) i_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_i   (start),
    .cen_i    (cen),
    .reload_i (n_q),
    .cnt_o    (cnt_q),
    .irq_o    (irq)
  );

  initial begin
    assert (TOTAL_W == PRE_W + CNT_W && CNT_W >= PRE_W && CNT_W >= 2 && SYNC_STAGES >= 2)
      else $error("tmr_evt_counter: bad parameters");
  end

  // R7: a stopped counter holds its readback value
  p_stop_freeze_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !start) |=> $stable(cnt_q));
  // R8: rewriting run while running never reloads the count
  p_no_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && wr_c && !cen) |=> $stable(cnt_q));
endmodule

// File: tb/test_tmr_evt_counter.sv
module test_tmr_evt_counter;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_en;
  logic [1:0] wr_sel;
  logic [7:0] wr_data;
  logic       evt_in;
  logic [7:0] cnt_q;
  logic       irq;

  int checks = 0;
  int errors = 0;
  string phase = "R1";
  bit cmp_on = 1'b0;
  int irq_seen = 0;

  always #5 clk = ~clk;

  tmr_evt_counter i_tmr_evt_counter (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .evt_in(evt_in), .cnt_q(cnt_q), .irq(irq)
  );

  // behavioural reference
  int m_div, m_pre, m_cnt, m_n, m_p;
  bit m_run, m_ext, m_irq, m_s1, m_s2, m_s3;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_div = 0; m_pre = 0; m_cnt = 0; m_n = 0; m_p = 0;
      m_run = 0; m_ext = 0; m_irq = 0; m_s1 = 0; m_s2 = 0; m_s3 = 0;
    end else begin
      bit t_int, t_ext, tk, st, step;
      t_int = (m_div == 15);
      m_div = (m_div + 1) % 16;
      t_ext = m_s2 && !m_s3;
      m_s3 = m_s2; m_s2 = m_s1; m_s1 = evt_in;
      tk = m_ext ? t_ext : t_int;
      st = wr_en && wr_sel == 2 && wr_data[0] && !m_run;
      step = m_run && tk && m_pre == 0;
      m_irq = step && m_cnt == 0;
      if (st) begin
        m_pre = m_p; m_cnt = m_n;
      end else if (m_run && tk) begin
        m_pre = (m_pre == 0) ? m_p : m_pre - 1;
        if (step) m_cnt = (m_cnt == 0) ? m_n : m_cnt - 1;
      end
      if (wr_en) begin
        case (wr_sel)
          2'd0: m_n = wr_data;
          2'd1: m_p = wr_data[4:0];
          2'd2: begin m_run = wr_data[0]; m_ext = wr_data[1]; end
          default: ;
        endcase
      end
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_on) begin
      chk({phase, " count"}, cnt_q, m_cnt);
      chk({phase, " irq"}, irq, m_irq);
      if (irq) irq_seen++;
    end
  end

  task automatic wr(int sel, int data);
    wr_en = 1'b1; wr_sel = sel[1:0]; wr_data = data[7:0];
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_sel = '0; wr_data = '0; evt_in = 1'b0;
    idle(3);
    chk("R1 reset count", cnt_q, 0);   // R1
    chk("R1 reset irq", irq, 0);
    rst_n = 1'b1;
    cmp_on = 1'b1;
    phase = "R9";                     // R9: select 3 touches nothing
    wr(3, 8'hFF); idle(40);
    chk("R9 count still zero", cnt_q, 0);
    phase = "R2";                     // R2/R4: internal ticks, N=3, P=0
    wr(0, 3); wr(1, 0); wr(2, 1); idle(200);
    chk("R4 irq observed", (irq_seen > 0) ? 1 : 0, 1);
    phase = "R3";                     // R3: prescale 2
    wr(1, 2); idle(400);
    phase = "R8";                     // R8: run rewrite while running
    wr(2, 1); idle(100);
    phase = "R7";                     // R7: stop freezes
    wr(2, 0); idle(100);
    phase = "R6";                     // R6: start loads both stages
    wr(0, 5); wr(1, 1); wr(2, 1); idle(300);
    phase = "R5";                     // R5: external rising edges
    wr(2, 0); wr(1, 0); wr(0, 4); wr(2, 3);
    for (int i = 0; i < 60; i++) begin
      evt_in = 1'b1; idle(2 + i % 3);
      evt_in = 1'b0; idle(2 + i % 2);
    end
    evt_in = 1'b1; idle(50);          // held level: no counts
    phase = "R11";                    // R11: internal selected, pin ignored
    wr(2, 1);
    for (int i = 0; i < 50; i++) begin
      evt_in = ~evt_in; idle(2);
    end
    phase = "R10";                    // R10: reload write meets terminal count
    wr(2, 0); wr(0, 1); wr(2, 3);
    for (int i = 0; i < 120; i++) begin
      evt_in = i[1];
      wr_en = 1'b1; wr_sel = 2'd0; wr_data = (i % 2 == 0) ? 8'd2 : 8'd1;
      @(negedge clk);
    end
    wr_en = 1'b0; idle(20);
    cmp_on = 1'b0;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual hung expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule